// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Macro

This block is a behavioural model of a single-port synchronous SRAM with its control front end. All controls are active low: chip select, write enable and output enable. On every rising clock edge the block registers the controls and the address. The work of the cycle then happens on the falling edge of that same cycle. A write stores the data-in bus into the array on the falling edge. A read loads the addressed word on the falling edge, so data-out is valid in the second half of the cycle.

Because every operation finishes inside its own cycle, reads and writes can follow each other in any order with no idle cycles between them. The storage is split into 1, 2 or 4 banks. Each row holds 1, 2 or 4 words, and a column multiplexer picks one of them. The address splits into bank, row and column fields. The array has no reset, so it can map onto block RAM.

Top module: `sram_zbt_top`

## Requirements
- R1: While the active-high synchronous reset is applied, and after it is released, no operation takes place until one is requested, and data-out reads all zeros.
- R2: Chip select (low = selected), write enable (low = write, high = read), output enable and the address are sampled at the rising clock edge. Changes between that edge and the next rising edge have no effect on the current cycle.
- R3: A read cycle has chip select low and write enable high. The addressed word appears on data-out after the falling edge of the same cycle when output enable is low.
- R4: A write cycle has chip select low and write enable low. It stores the value that data-in holds at the falling edge of that cycle, and it leaves data-out unchanged.
- R5: Operations may be issued on every cycle in any mix. A read of an address written in the cycle just before returns the newly written data.
- R6: The address is split, from most to least significant, into bank (log2 of the bank count bits), row (log2 of the row count bits) and column (log2 of the words per row bits). Every address has its own independent storage word.
- R7: In a cycle with chip select high the array is unchanged and data-out keeps its value.
- R8: In a cycle whose sampled output enable is high, data-out is all zeros after that cycle's falling edge. Otherwise data-out shows the word from the most recent read, including a read made while output enable was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; controls are registered on the rise, data moves on the fall |
| rst | input | 1 | Synchronous active-high reset of the control and output path |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low; high selects a read |
| oe_n | input | 1 | Output enable, active low; high forces data-out to zero |
| addr | input | ADDR_W | Word address: bank, row, column from MSB to LSB |
| din | input | DATA_W | Write data, sampled on the falling edge |
| dout | output | DATA_W | Read data, updated on the falling edge |

## Verification
The checker assumes that data-in stays constant from the rising edge to the falling edge of each cycle. Under that assumption the value seen at the rising edge equals the value written, and the forwarding and hold properties are stated against it. The bench changes its inputs shortly after each falling edge, which keeps every input steady across the whole next cycle. Two directed cases break that rule on purpose: one moves the address and controls after the rise, and one moves data-in after the rise. In each of them an idle cycle separates the disturbed write from the read that checks it, so the write-then-read property never sees the disturbed value.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

endpackage

// File: rtl/sram_front.sv
module sram_front
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BANK_W  = 1,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 1,
  parameter int BANK_IW = 1,
  parameter int COL_IW  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic [ADDR_W-1:0]  addr,
  output sram_op_e           op_q,
  output logic               oe_q,
  output logic [BANK_IW-1:0] bank_q,
  output logic [ROW_W-1:0]   row_q,
  output logic [COL_IW-1:0]  col_q
);

  logic [BANK_IW-1:0] bank_d;
  logic [ROW_W-1:0]   row_d;
  logic [COL_IW-1:0]  col_d;
  sram_op_e           op_d;

  if (BANK_W > 0) begin : g_bank
    assign bank_d = addr[ADDR_W-1 -: BANK_IW];
  end else begin : g_nobank
    assign bank_d = '0;
  end

  if (COL_W > 0) begin : g_col
    assign col_d = addr[COL_IW-1:0];
  end else begin : g_nocol
    assign col_d = '0;
  end

  assign row_d = addr[COL_W +: ROW_W];

  always_comb begin
    if (cs_n)      op_d = OP_IDLE;
    else if (we_n) op_d = OP_READ;
    else           op_d = OP_WRITE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      oe_q   <= 1'b1;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      op_q   <= op_d;
      oe_q   <= oe_n;
      bank_q <= bank_d;
      row_q  <= row_d;
      col_q  <= col_d;
    end
  end

endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
  parameter int DATA_W  = 8,
  parameter int ROWS    = 16,
  parameter int COL_MUX = 2,
  parameter int ROW_W   = 4,
  parameter int COL_IW  = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ROW_W-1:0]            row,
  input  logic [COL_IW-1:0]           col,
  input  logic [DATA_W-1:0]           din,
  output logic [COL_MUX*DATA_W-1:0]   rd_row
);

  for (genvar c = 0; c < COL_MUX; c++) begin : g_colmem
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rd_word;
    logic              sel;

    assign sel = (int'(col) == c);

    always_ff @(negedge clk) begin
      if (wr_en && sel) begin
        mem[row] <= din;
      end
    end

    always_ff @(negedge clk) begin
      if (rst) begin
        rd_word <= '0;
      end else if (rd_en) begin
        rd_word <= mem[row];
      end
    end

    assign rd_row[c*DATA_W +: DATA_W] = rd_word;
  end

endmodule

// File: rtl/sram_rdsel.sv
module sram_rdsel #(
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int COL_MUX   = 2,
  parameter int BANK_IW   = 1,
  parameter int COL_IW    = 1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  rd_fire,
  input  logic                                  oe_q,
  input  logic [BANK_IW-1:0]                    bank_q,
  input  logic [COL_IW-1:0]                     col_q,
  input  logic [NUM_BANKS*COL_MUX*DATA_W-1:0]   rows_flat,
  output logic [DATA_W-1:0]                     dout
);

  localparam int WORDS = NUM_BANKS * COL_MUX;

  logic [BANK_IW-1:0] sel_bank;
  logic [COL_IW-1:0]  sel_col;
  logic               idle_l;
  int unsigned        word_idx;

  // Latched on the falling edge so the selection stays put while the
  // front end registers the next cycle's address.
  always_ff @(negedge clk) begin
    if (rst) begin
      sel_bank <= '0;
      sel_col  <= '0;
      idle_l   <= 1'b1;
    end else begin
      idle_l <= oe_q;
      if (rd_fire) begin
        sel_bank <= bank_q;
        sel_col  <= col_q;
      end
    end
  end

  always_comb begin
    word_idx = int'(sel_bank) * COL_MUX + int'(sel_col);
    if (word_idx >= WORDS) word_idx = 0;
  end

  assign dout = idle_l ? '0 : rows_flat[word_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/sram_zbt_top.sv
module sram_zbt_top
  import sram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int ROWS      = 16,
  parameter int COL_MUX   = 2,
  localparam int ADDR_W   = $clog2(NUM_BANKS) + $clog2(ROWS) + $clog2(COL_MUX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int ROW_W   = $clog2(ROWS);
  localparam int COL_W   = $clog2(COL_MUX);
  localparam int BANK_IW = (BANK_W > 0) ? BANK_W : 1;
  localparam int COL_IW  = (COL_W > 0) ? COL_W : 1;
  localparam int ROW_BITS = COL_MUX * DATA_W;

  sram_op_e           op_q;
  logic               oe_q;
  logic [BANK_IW-1:0] bank_q;
  logic [ROW_W-1:0]   row_q;
  logic [COL_IW-1:0]  col_q;
  logic [NUM_BANKS*ROW_BITS-1:0] rows_flat;
  logic               rd_fire;

  sram_front #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .BANK_IW(BANK_IW),
    .COL_IW (COL_IW)
  ) u_front (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .addr  (addr),
    .op_q  (op_q),
    .oe_q  (oe_q),
    .bank_q(bank_q),
    .row_q (row_q),
    .col_q (col_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (int'(bank_q) == b);

    sram_bank #(
      .DATA_W (DATA_W),
      .ROWS   (ROWS),
      .COL_MUX(COL_MUX),
      .ROW_W  (ROW_W),
      .COL_IW (COL_IW)
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr_en (hit && (op_q == OP_WRITE)),
      .rd_en (hit && (op_q == OP_READ)),
      .row   (row_q),
      .col   (col_q),
      .din   (din),
      .rd_row(rows_flat[b*ROW_BITS +: ROW_BITS])
    );
  end

  assign rd_fire = (op_q == OP_READ);

  sram_rdsel #(
    .DATA_W   (DATA_W),
    .NUM_BANKS(NUM_BANKS),
    .COL_MUX  (COL_MUX),
    .BANK_IW  (BANK_IW),
    .COL_IW   (COL_IW)
  ) u_rdsel (
    .clk      (clk),
    .rst      (rst),
    .rd_fire  (rd_fire),
    .oe_q     (oe_q),
    .bank_q   (bank_q),
    .col_q    (col_q),
    .rows_flat(rows_flat),
    .dout     (dout)
  );

endmodule

// File: rtl/sram_zbt_chk.sv
module sram_zbt_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout
);

  logic [1:0] age;
  logic       rd;
  logic       wr;

  assign rd = !cs_n && we_n;
  assign wr = !cs_n && !we_n;

  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == '0)); // R1

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(oe_n) |-> (dout == '0)); // R8

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(cs_n) && !$past(oe_n) && !$past(oe_n, 2))
      |-> $stable(dout)); // R7

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(wr) && !$past(oe_n) && !$past(oe_n, 2))
      |-> $stable(dout)); // R4

  AST_RAW_FWD: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(rd) && !$past(oe_n) && $past(wr, 2)
     && ($past(addr) == $past(addr, 2)))
      |-> (dout == $past(din, 2))); // R5

endmodule

bind sram_zbt_top sram_zbt_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk (clk),
  .rst (rst),
  .cs_n(cs_n),
  .we_n(we_n),
  .oe_n(oe_n),
  .addr(addr),
  .din (din),
  .dout(dout)
);

// File: tb/sram_zbt_top_tb.sv
`timescale 1ns/1ps
module sram_zbt_top_tb;

  localparam int DW = 8;
  localparam int NB = 2;
  localparam int NR = 16;
  localparam int CM = 2;
  localparam int AW = $clog2(NB) + $clog2(NR) + $clog2(CM);
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] ref_last = '0;
  logic [DW-1:0] ref_out  = '0;

  always #4 clk = ~clk;

  sram_zbt_top #(.DATA_W(DW), .NUM_BANKS(NB), .ROWS(NR), .COL_MUX(CM)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout)
  );

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 37 + 5);
  endfunction

  task automatic model(input logic c, input logic w, input logic o,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (!c && w)  ref_last = ref_mem[a];
    if (!c && !w) ref_mem[a] = d;
    ref_out = o ? '0 : ref_last;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%h expected %h", tag, act, exp);
    end
  endtask

  // Inputs are applied 2 ns after a falling edge; the result is sampled
  // 2 ns after the next falling edge, which belongs to the same cycle.
  task automatic do_op(input logic c, input logic w, input logic o,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input string tag);
    cs_n = c; we_n = w; oe_n = o; addr = a; din = d;
    @(posedge clk);
    @(negedge clk);
    #2;
    model(c, w, o, a, d);
    check(tag, dout, ref_out);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: dout=%h expected %h", dout, ref_out);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] ga;
    logic [AW-1:0] gb;
    void'($urandom(32'h5eed_0123));

    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    check("R1 reset", dout, '0);
    rst = 1'b0;
    do_op(1'b1, 1'b1, 1'b0, '0, '0, "R1 after reset");

    // R6: fill every address then read each back; field split bank|row|col
    for (int a = 0; a < DEPTH; a++)
      do_op(1'b0, 1'b0, 1'b0, AW'(a), pat(a), "R4 fill write");
    for (int a = 0; a < DEPTH; a++)
      do_op(1'b0, 1'b1, 1'b0, AW'(a), '0, "R6 readback");

    // R5: write then read the same address on consecutive cycles
    do_op(1'b0, 1'b0, 1'b0, AW'(9), 8'hA5, "R5 write");
    do_op(1'b0, 1'b1, 1'b0, AW'(9), '0, "R5 read after write");
    do_op(1'b0, 1'b0, 1'b0, AW'(DEPTH-1), 8'h3C, "R5 write top");
    do_op(1'b0, 1'b1, 1'b0, AW'(DEPTH-1), '0, "R5 read top");
    do_op(1'b0, 1'b1, 1'b0, AW'(0), '0, "R3 read low");

    // R8: read with output enable high gives zero; latch still updated
    do_op(1'b0, 1'b1, 1'b1, AW'(17), '0, "R8 read oe high");
    do_op(1'b1, 1'b1, 1'b0, AW'(0), '0, "R8 shows last read");

    // R7: deselected write attempt changes nothing
    do_op(1'b1, 1'b0, 1'b0, AW'(33), 8'hEE, "R7 deselected write");
    do_op(1'b0, 1'b1, 1'b0, AW'(33), '0, "R7 array unchanged");

    // R2: address and controls moved after the rising edge are ignored
    ga = AW'(40);
    gb = AW'(41);
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = ga; din = '0;
    @(posedge clk);
    #1;
    addr = gb; we_n = 1'b0; cs_n = 1'b1; din = 8'h77;
    @(negedge clk);
    #2;
    model(1'b0, 1'b1, 1'b0, ga, '0);
    check("R2 late change ignored", dout, ref_out);
    do_op(1'b0, 1'b1, 1'b0, gb, '0, "R2 no stray write");

    // R4: data-in is taken at the falling edge, not at the rising edge
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = AW'(50); din = 8'h11;
    @(posedge clk);
    #1;
    din = 8'h99;
    @(negedge clk);
    #2;
    model(1'b0, 1'b0, 1'b0, AW'(50), 8'h99);
    check("R4 write hold", dout, ref_out);
    do_op(1'b1, 1'b1, 1'b0, '0, '0, "R7 idle gap");
    do_op(1'b0, 1'b1, 1'b0, AW'(50), '0, "R4 falling-edge data");

    // Random mixed traffic with no idle cycles forced between operations
    for (int i = 0; i < 3000; i++) begin
      logic c;
      logic w;
      logic o;
      string tag;
      c = (($urandom % 8) == 0);
      w = $urandom % 2;
      o = (($urandom % 6) == 0);
      if (c)      tag = "R7 random deselect";
      else if (o) tag = "R8 random oe high";
      else if (w) tag = "R3 random read";
      else        tag = "R5 random write";
      do_op(c, w, o, AW'($urandom % DEPTH), DW'($urandom), tag);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule